// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one 16-bit instruction word of a small 32-bit processor with sixteen general registers into the control fields that the execute stage needs. The leading bits of the word pick one of three layouts: a register form with an 8-bit opcode and two register nibbles, an immediate form with a register and an 8-bit constant, and a conditional branch form with a condition and a signed offset. The outputs are the format, a one-hot operation class, register indices, the short immediate, the branch condition and offset, the instruction length in bytes, a flag for a following 32-bit extension word, a shift flag and an illegal-instruction flag.

The decode logic is combinational and feeds one output register. A word presented with `in_valid` high appears decoded on the outputs one clock later, with `out_valid` high. Fetching the extension word is up to the fetch stage, which learns from `has_ext` that four more bytes belong to the instruction.

Top module: `insn_decoder`

## Requirements
- R1: While `rst_n` is low and after it rises, before any valid word, `out_valid` is 0 and every decoded field is 0.
- R2: `out_valid` in the cycle after a clock edge equals the `in_valid` sampled at that edge.
- R3: A word with bits 15 and 14 both set gives `fmt` = 2'b11, `br_cond` = bits 13:10, `op_code` = {4'b0, bits 13:10}, and `br_off` = bits 9:0 read as a signed word count, sign-extended and multiplied by two (a byte offset).
- R4: In the branch form, conditions 0 to 9 decode to the branch class; conditions 10 to 15 are illegal.
- R5: A word with bit 15 set and bit 14 clear gives `fmt` = 2'b10, `op_code` = {6'b0, bits 13:12}, `reg_a` = bits 11:8, `imm8` = bits 7:0, `reg_b` = 0; codes 0 and 1 (add and subtract immediate) give the ALU class and codes 2 and 3 (read and write a special register) give the special-register class.
- R6: A word with bit 15 clear gives `fmt` = 2'b00, `op_code` = bits 15:8, `reg_a` = bits 7:4 and `reg_b` = bits 3:0.
- R7: Register-form opcodes 01, 03, 08, 09, 0C, 0D, 1A, 1B, 1D, 1F, 20, 22, 24, 30, 36, 37, 38 and 39 (hex) set `has_ext` and give `len_bytes` = 6.
- R8: Every other decoded word, legal or illegal, gives `has_ext` = 0 and `len_bytes` = 2.
- R9: Register-form opcodes 0F to 18 and 3A to 7F (hex) set `illegal` and give `op_class` = 0.
- R10: `op_class` bits are ALU 0, load 1, store 2, branch 3, call 4, return 5, special register 6, trap 7; a legal word sets exactly one bit. Loads are 07 0A 1C 21 08 0C 1D 22 36 38; stores 06 0B 1E 23 09 0D 1F 24 37 39; call 03 19; return 04; branch 1A 25; trap 30 35; the remaining legal register-form opcodes are ALU.
- R11: `shift_op` is 1 exactly for register-form opcodes 27, 28 and 2D, telling the datapath to use only the low 5 bits of the second register.
- R12: While `in_valid` is low, every decoded field keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word strobe |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded fields valid |
| fmt | output | 2 | Format: 00 register, 10 immediate, 11 branch |
| op_code | output | 8 | Operation code within the format |
| op_class | output | 8 | One-hot operation class |
| reg_a | output | 4 | First / destination register |
| reg_b | output | 4 | Second register |
| imm8 | output | 8 | Short immediate or special-register index |
| br_cond | output | 4 | Branch condition |
| br_off | output | XLEN | Signed byte offset of a branch |
| len_bytes | output | 3 | Instruction length, 2 or 6 |
| has_ext | output | 1 | A 32-bit extension word follows |
| shift_op | output | 1 | Shift amount uses the low 5 bits only |
| illegal | output | 1 | Unrecognised instruction |

## Verification
Every decoded result is due exactly one clock after the edge that samples the word, since there is a single register between input and output. The bench applies inputs just after the falling edge, so the rising edge between captures them, and compares all outputs at the next falling edge against a behavioural model updated at the same moment it drives; idle cycles check that fields stay put. All 65536 words are swept, with idle cycles interleaved.

// File: rtl/insn_decoder.sv
module insn_decoder #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [15:0]     in_word,
  output logic            out_valid,
  output logic [1:0]      fmt,
  output logic [7:0]      op_code,
  output logic [7:0]      op_class,
  output logic [3:0]      reg_a,
  output logic [3:0]      reg_b,
  output logic [7:0]      imm8,
  output logic [3:0]      br_cond,
  output logic [XLEN-1:0] br_off,
  output logic [2:0]      len_bytes,
  output logic            has_ext,
  output logic            shift_op,
  output logic            illegal
);

  localparam int OFFW = 10;
  localparam logic [7:0] C_ALU = 8'h01, C_LD = 8'h02, C_ST = 8'h04, C_BR = 8'h08,
                         C_CALL = 8'h10, C_RET = 8'h20, C_SREG = 8'h40, C_TRAP = 8'h80;

  logic [1:0]      d_fmt;
  logic [7:0]      d_code, d_class, d_imm;
  logic [3:0]      d_ra, d_rb, d_cond;
  logic [XLEN-1:0] d_off;
  logic            d_ext, d_shift, d_ill;

  always_comb begin
    d_fmt   = 2'b00;
    d_code  = 8'h00;
    d_class = 8'h00;
    d_imm   = 8'h00;
    d_ra    = 4'h0;
    d_rb    = 4'h0;
    d_cond  = 4'h0;
    d_off   = '0;
    d_ext   = 1'b0;
    d_shift = 1'b0;
    d_ill   = 1'b0;
    if (!in_word[15]) begin
      d_code = in_word[15:8];
      d_ra   = in_word[7:4];
      d_rb   = in_word[3:0];
      case (d_code)
        8'h00, 8'h02, 8'h05, 8'h0e, 8'h26, 8'h29, 8'h2a, 8'h2b, 8'h2c,
        8'h2e, 8'h2f, 8'h31, 8'h32, 8'h33, 8'h34:  d_class = C_ALU;
        8'h27, 8'h28, 8'h2d: begin d_class = C_ALU; d_shift = 1'b1; end
        8'h01, 8'h1b, 8'h20: begin d_class = C_ALU;  d_ext = 1'b1; end
        8'h07, 8'h0a, 8'h1c, 8'h21:                d_class = C_LD;
        8'h08, 8'h0c, 8'h1d, 8'h22, 8'h36, 8'h38:
                             begin d_class = C_LD;   d_ext = 1'b1; end
        8'h06, 8'h0b, 8'h1e, 8'h23:                d_class = C_ST;
        8'h09, 8'h0d, 8'h1f, 8'h24, 8'h37, 8'h39:
                             begin d_class = C_ST;   d_ext = 1'b1; end
        8'h03:               begin d_class = C_CALL; d_ext = 1'b1; end
        8'h19:                                     d_class = C_CALL;
        8'h04:                                     d_class = C_RET;
        8'h1a:               begin d_class = C_BR;   d_ext = 1'b1; end
        8'h25:                                     d_class = C_BR;
        8'h30:               begin d_class = C_TRAP; d_ext = 1'b1; end
        8'h35:                                     d_class = C_TRAP;
        default:                                   d_ill = 1'b1;
      endcase
    end else if (!in_word[14]) begin
      d_fmt   = 2'b10;
      d_code  = {6'b0, in_word[13:12]};
      d_ra    = in_word[11:8];
      d_imm   = in_word[7:0];
      d_class = in_word[13] ? C_SREG : C_ALU;
    end else begin
      d_fmt  = 2'b11;
      d_cond = in_word[13:10];
      d_code = {4'b0, d_cond};
      d_off  = {{(XLEN-OFFW-1){in_word[OFFW-1]}}, in_word[OFFW-1:0], 1'b0};
      if (d_cond <= 4'd9) d_class = C_BR;
      else                d_ill   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fmt       <= '0;
      op_code   <= '0;
      op_class  <= '0;
      reg_a     <= '0;
      reg_b     <= '0;
      imm8      <= '0;
      br_cond   <= '0;
      br_off    <= '0;
      len_bytes <= '0;
      has_ext   <= 1'b0;
      shift_op  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fmt       <= d_fmt;
        op_code   <= d_code;
        op_class  <= d_class;
        reg_a     <= d_ra;
        reg_b     <= d_rb;
        imm8      <= d_imm;
        br_cond   <= d_cond;
        br_off    <= d_off;
        len_bytes <= d_ext ? 3'd6 : 3'd2;
        has_ext   <= d_ext;
        shift_op  <= d_shift;
        illegal   <= d_ill;
      end
    end
  end

endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [15:0]     in_word,
  input logic            out_valid,
  input logic [1:0]      fmt,
  input logic [7:0]      op_code,
  input logic [7:0]      op_class,
  input logic [3:0]      reg_a,
  input logic [3:0]      reg_b,
  input logic [7:0]      imm8,
  input logic [3:0]      br_cond,
  input logic [XLEN-1:0] br_off,
  input logic [2:0]      len_bytes,
  input logic            has_ext,
  input logic            shift_op,
  input logic            illegal
);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_ext_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && has_ext |-> len_bytes == 3'd6 && !illegal);
  p_short_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !has_ext |-> len_bytes == 3'd2);
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !illegal |-> $countones(op_class) == 1);
  p_illegal_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> op_class == 8'h00);
  p_branch_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && fmt == 2'b11 && !illegal |-> br_cond <= 4'd9 && op_class == 8'h08);
  p_branch_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && fmt == 2'b11 |-> br_off[0] == 1'b0 && br_off[XLEN-1] == br_off[10]);
  p_shift_alu_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && shift_op |-> op_class == 8'h01 && fmt == 2'b00);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(op_class) && $stable(op_code) && $stable(br_off) && $stable(len_bytes));

endmodule

bind insn_decoder insn_decoder_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_insn_decoder.sv
module test_insn_decoder;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic out_valid, has_ext, shift_op, illegal;
  logic [1:0] fmt;
  logic [7:0] op_code, op_class, imm8;
  logic [3:0] reg_a, reg_b, br_cond;
  logic [XLEN-1:0] br_off;
  logic [2:0] len_bytes;

  insn_decoder #(.XLEN(XLEN)) i_insn_decoder (.*);

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic e_valid = 1'b0, e_ext = 1'b0, e_shift = 1'b0, e_ill = 1'b0;
  logic [1:0] e_fmt = '0;
  logic [7:0] e_code = '0, e_class = '0, e_imm = '0;
  logic [3:0] e_ra = '0, e_rb = '0, e_cond = '0;
  logic [XLEN-1:0] e_off = '0;
  logic [2:0] e_len = '0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h (word %h)", tag, act, exp, in_word);
    end
  endtask

  task automatic model(input logic [15:0] w);
    int op;
    e_valid = 1'b1; e_ext = 0; e_shift = 0; e_ill = 0;
    e_imm = 0; e_ra = 0; e_rb = 0; e_cond = 0; e_off = 0; e_class = 0;
    if (w[15] == 1'b0) begin
      op = int'(w[15:8]);
      e_fmt = 2'b00; e_code = w[15:8]; e_ra = w[7:4]; e_rb = w[3:0];
      if (op inside {8'h07, 8'h0a, 8'h1c, 8'h21, 8'h08, 8'h0c, 8'h1d, 8'h22, 8'h36, 8'h38})
        e_class = 8'h02;
      else if (op inside {8'h06, 8'h0b, 8'h1e, 8'h23, 8'h09, 8'h0d, 8'h1f, 8'h24, 8'h37, 8'h39})
        e_class = 8'h04;
      else if (op inside {8'h03, 8'h19}) e_class = 8'h10;
      else if (op == 8'h04) e_class = 8'h20;
      else if (op inside {8'h1a, 8'h25}) e_class = 8'h08;
      else if (op inside {8'h30, 8'h35}) e_class = 8'h80;
      else if ((op >= 8'h0f && op <= 8'h18) || op >= 8'h3a) e_ill = 1'b1;
      else e_class = 8'h01;
      e_ext = op inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0c, 8'h0d, 8'h1a, 8'h1b, 8'h1d,
                         8'h1f, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39};
      e_shift = op inside {8'h27, 8'h28, 8'h2d};
    end else if (w[14] == 1'b0) begin
      e_fmt = 2'b10; e_code = 8'(w[13:12]); e_ra = w[11:8]; e_imm = w[7:0];
      e_class = (w[13:12] >= 2) ? 8'h40 : 8'h01;
    end else begin
      e_fmt = 2'b11; e_cond = w[13:10]; e_code = 8'(w[13:10]);
      e_off = XLEN'($signed(w[9:0]) * 2);
      if (w[13:10] < 10) e_class = 8'h08; else e_ill = 1'b1;
    end
    e_len = e_ext ? 3'd6 : 3'd2;
  endtask

  task automatic compare(input string htag);
    check("R2 out_valid", out_valid, e_valid);
    check({htag, " class R10/R9"}, op_class, e_class);
    check({htag, " illegal R9/R4"}, illegal, e_ill);
    check({htag, " fmt R6/R5/R3"}, fmt, e_fmt);
    check({htag, " op_code R6"}, op_code, e_code);
    check({htag, " regs R6/R5"}, {reg_a, reg_b}, {e_ra, e_rb});
    check({htag, " imm8 R5"}, imm8, e_imm);
    check({htag, " branch R3"}, {br_cond, br_off}, {e_cond, e_off});
    check({htag, e_ext ? " length R7" : " length R8"}, {has_ext, len_bytes}, {e_ext, e_len});
    check({htag, " shift R11"}, shift_op, e_shift);
  endtask

  task automatic step(input logic v, input logic [15:0] w);
    @(negedge clk);
    compare(e_valid ? "decode" : "R12 hold");
    in_valid = v;
    in_word = w;
    if (v) model(w); else e_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=%0d expected<200000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    in_word = 16'hffff;
    repeat (3) @(negedge clk);
    check("R1 reset valid", out_valid, 0);
    check("R1 reset fields", {op_class, len_bytes, br_off}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {out_valid, op_class, has_ext, illegal}, 0);
    step(1, 16'h0123);
    step(1, 16'hc3ff);
    step(0, 16'h3a00);
    step(1, 16'hfc01);
    step(1, 16'h9a5c);
    step(1, 16'h2745);
    step(0, 16'h0000);
    step(0, 16'hffff);
    for (int i = 0; i < 65536; i++) begin
      step(1, 16'(i));
      if (i % 7 == 3) step(0, 16'(i * 31));
    end
    step(0, 16'h0000);
    step(0, 16'h0000);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule